// File: doc/BRIEF.md
# Four-Channel Serial Sampling Converter Control

This block is the digital control side of a four-channel, 16-bit sampling converter with a serial result port. The analog core is modelled by a conversion timer. At the moment a conversion is accepted, the timer captures a word from the `sample_i` test input. It then holds the busy flag low for a fixed number of system clocks. After that it commits the word to the result register.

One pair of strobes does two jobs: it starts conversions and it opens reads. The order of the edges decides which. Chip select and the read/convert strobe are both asynchronous. Each passes through a two-stage synchronizer before edge detection.

The result leaves most significant bit first, in one of two ways. In self-clocked mode, every accepted conversion makes the block generate sixteen data-clock periods carrying the previous result. In external-clock mode, a read sequence shifts the word out on the rising edges of a supplied clock, and a frame-sync pulse marks the first bit. That read can fetch the previous result while a conversion is running, or the new one after it ends.

A power-down level blocks new conversions. A channel-address latch is open only while both write strobes are low.

Top module: `serial_adc_ctrl`

## Requirements
- R1: With chip select low, a falling edge of the read/convert strobe starts a conversion.
- R2: With the read/convert strobe low, a falling edge of chip select starts a conversion.
- R3: After an accepted start, `busy_no` is low for exactly CONV_CYCLES system clocks. When it returns high, the result register holds the `sample_i` word captured at the start.
- R4: A start request while `busy_no` is low is ignored. The running conversion and its result are unaffected, and `err_o` is high for exactly one clock.
- R5: While power-down is high, start requests are ignored: `busy_no` stays high, no serial output begins, and the stored result is kept.
- R6: In self-clocked mode (`ext_sel_i` = 0), every accepted start produces exactly 16 high pulses on `dclk_o`. These carry the result from before that start, MSB first. `sdata_o` is stable across both edges of each pulse. In external-clock mode `dclk_o` stays low.
- R7: In external-clock mode (`ext_sel_i` = 1), either of two conditions opens a read: a rising edge of the read/convert strobe with chip select low, or a falling edge of chip select with the strobe high. Then the n-th rising edge of `ext_dclk_i` presents bit 15-n on `sdata_o`, for n = 0 to 15. `sync_o` is high only during the period that follows the first of those edges.
- R8: A read opened during a conversion returns the previous result. A read opened after the conversion ends returns the new result.
- R9: `chan_o` follows `addr_i` one clock later while both `wr_a_ni` and `wr_b_ni` are low. While either is high, `chan_o` holds. Codes 0 to 3 select channels 1 to 4.
- R10: After reset, `busy_no` = 1, `err_o` = 0, `dclk_o` = 0, `sync_o` = 0, `sdata_o` = 0 and `chan_o` = 0, and the result register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rc_i | input | 1 | Read (high) / convert (low) strobe, asynchronous |
| pd_i | input | 1 | Power-down level |
| ext_sel_i | input | 1 | Data-clock source: 0 self-clocked, 1 external |
| ext_dclk_i | input | 1 | External data clock |
| wr_a_ni | input | 1 | Address write strobe A, active low |
| wr_b_ni | input | 1 | Address write strobe B, active low |
| addr_i | input | 2 | Channel address code |
| sample_i | input | 16 | Stand-in for the quantized sample |
| busy_no | output | 1 | Low while a conversion runs |
| err_o | output | 1 | One-clock pulse on a start request made while busy |
| sdata_o | output | 1 | Serial result, MSB first |
| dclk_o | output | 1 | Data clock generated in self-clocked mode |
| sync_o | output | 1 | Frame sync for external-clock reads |
| chan_o | output | 2 | Latched channel code |

## Verification
Some behaviours are checked on every cycle by the assertions:
- the exact length of each busy window;
- the single-cycle error pulse;
- the rule that power-down keeps busy high;
- stability of the serial line across data-clock edges in self-clocked mode;
- the open and hold behaviour of the address latch.

Other behaviours only the bench's scenarios can show. One is which word is carried: the previous result in self-clocked mode, and before or after a conversion in external mode. Others are that both strobe orderings start a conversion, that a rejected start leaves the result intact, and the bit order and sync placement of external reads. These scenarios are swept over a set of data patterns.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef struct packed {
    logic start;
    logic read;
  } strobe_ev_t;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= RST_VAL;
      ff2_q <= RST_VAL;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = ff2_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CONV_CYCLES = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pd_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              err_o,
  output logic [WORD_W-1:0] result_o
);
  import adc_ctrl_pkg::*;
  localparam int unsigned CW = cnt_w(CONV_CYCLES);

  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] hold_q;
  logic              busy_q, err_q;

  assign accept_o = start_i & ~busy_q & ~pd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      hold_q   <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      result_o <= '0;
    end else begin
      err_q <= start_i & busy_q;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(CONV_CYCLES - 1);
        hold_q <= sample_i;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q   <= 1'b0;
          result_o <= hold_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
endmodule

// File: rtl/adc_int_tx.sv
module adc_int_tx #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned DCLK_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sdata_o,
  output logic              dclk_o
);
  import adc_ctrl_pkg::*;
  localparam int unsigned PER = 4 * DCLK_DIV;
  localparam int unsigned PW  = $clog2(PER);
  localparam int unsigned BW  = cnt_w(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [PW-1:0]     phase_q;
  logic [BW-1:0]     nbit_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      phase_q  <= '0;
      nbit_q   <= '0;
      active_q <= 1'b0;
    end else if (go_i) begin
      sh_q     <= word_i;
      phase_q  <= '0;
      nbit_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (phase_q == PW'(PER - 1)) begin
        // data moves only in the low gap between two pulses
        phase_q <= '0;
        sh_q    <= sh_q << 1;
        if (nbit_q == BW'(WORD_W - 1)) active_q <= 1'b0;
        else                          nbit_q   <= nbit_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign dclk_o  = active_q && (phase_q >= PW'(DCLK_DIV)) && (phase_q < PW'(3 * DCLK_DIV));
  assign sdata_o = active_q & sh_q[WORD_W-1];
endmodule

// File: rtl/adc_ext_tx.sv
module adc_ext_tx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              edge_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sdata_o,
  output logic              sync_o
);
  import adc_ctrl_pkg::*;
  localparam int unsigned BW = cnt_w(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [BW-1:0]     cnt_q;
  logic              active_q, out_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      out_q    <= 1'b0;
      sync_q   <= 1'b0;
    end else if (go_i && !active_q) begin
      sh_q     <= word_i;
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q && edge_i) begin
      if (cnt_q == BW'(WORD_W)) begin
        active_q <= 1'b0;
        out_q    <= 1'b0;
        sync_q   <= 1'b0;
      end else begin
        out_q  <= sh_q[WORD_W-1];
        sh_q   <= sh_q << 1;
        sync_q <= (cnt_q == '0);
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign sdata_o = out_q;
  assign sync_o  = sync_q;
endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned CONV_CYCLES = 80,
  parameter int unsigned DCLK_DIV    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rc_i,
  input  logic              pd_i,
  input  logic              ext_sel_i,
  input  logic              ext_dclk_i,
  input  logic              wr_a_ni,
  input  logic              wr_b_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              busy_no,
  output logic              err_o,
  output logic              sdata_o,
  output logic              dclk_o,
  output logic              sync_o,
  output logic [ADDR_W-1:0] chan_o
);
  import adc_ctrl_pkg::*;

  // sync order: {ext_dclk, ext_sel, pd, rc, cs_n}
  logic [4:0] raw, syn;
  logic       cs_s, rc_s, pd_s, ext_sel_s, edclk_s;
  logic       cs_p_q, rc_p_q, edclk_p_q;
  strobe_ev_t ev;

  assign raw = {ext_dclk_i, ext_sel_i, pd_i, rc_i, cs_ni};

  adc_sync #(.W(5), .RST_VAL(5'b00011)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {edclk_s, ext_sel_s, pd_s, rc_s, cs_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_p_q    <= 1'b1;
      rc_p_q    <= 1'b1;
      edclk_p_q <= 1'b0;
    end else begin
      cs_p_q    <= cs_s;
      rc_p_q    <= rc_s;
      edclk_p_q <= edclk_s;
    end
  end

  logic cs_fall, rc_fall, rc_rise, edclk_rise;
  assign cs_fall    = cs_p_q & ~cs_s;
  assign rc_fall    = rc_p_q & ~rc_s;
  assign rc_rise    = ~rc_p_q & rc_s;
  assign edclk_rise = ~edclk_p_q & edclk_s;

  assign ev.start = (rc_fall & ~cs_s) | (cs_fall & ~rc_s);
  assign ev.read  = (rc_rise & ~cs_s) | (cs_fall & rc_s);

  logic              busy, accept;
  logic [WORD_W-1:0] result;

  adc_conv_timer #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ev.start), .pd_i(pd_s),
    .sample_i(sample_i), .busy_o(busy), .accept_o(accept), .err_o(err_o),
    .result_o(result)
  );

  logic int_sd, int_dclk, ext_sd;

  adc_int_tx #(.WORD_W(WORD_W), .DCLK_DIV(DCLK_DIV)) u_int (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(accept & ~ext_sel_s),
    .word_i(result), .sdata_o(int_sd), .dclk_o(int_dclk)
  );

  adc_ext_tx #(.WORD_W(WORD_W)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(ev.read & ext_sel_s),
    .edge_i(edclk_rise), .word_i(result), .sdata_o(ext_sd), .sync_o(sync_o)
  );

  assign busy_no = ~busy;
  assign sdata_o = ext_sel_s ? ext_sd : int_sd;
  assign dclk_o  = int_dclk & ~ext_sel_s;

  // address latch: open while both write strobes are low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   chan_o <= '0;
    else if (!(wr_a_ni | wr_b_ni)) chan_o <= addr_i;
  end
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned CONV_CYCLES = 80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_no,
  input logic              err_o,
  input logic              sdata_o,
  input logic              dclk_o,
  input logic [ADDR_W-1:0] chan_o,
  input logic              wr_a_ni,
  input logic              wr_b_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              pd_s,
  input logic              ext_sel_s
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt <= '0;
    else if (!busy_no) low_cnt <= low_cnt + 1;
    else              low_cnt <= '0;
  end

  a_r3_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_no && low_cnt != 0) |-> (low_cnt == CONV_CYCLES));

  a_r4_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r5_pd_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_s && busy_no) |=> busy_no);

  a_r6_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dclk_o) && !ext_sel_s && !$past(ext_sel_s)) |-> $stable(sdata_o));

  a_r9_latch_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_a_ni && !wr_b_ni) |=> (chan_o == $past(addr_i)));

  a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_ni || wr_b_ni) |=> $stable(chan_o));
endmodule

bind serial_adc_ctrl adc_ctrl_chk #(.ADDR_W(ADDR_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_no(busy_no), .err_o(err_o),
  .sdata_o(sdata_o), .dclk_o(dclk_o), .chan_o(chan_o), .wr_a_ni(wr_a_ni),
  .wr_b_ni(wr_b_ni), .addr_i(addr_i), .pd_s(pd_s), .ext_sel_s(ext_sel_s)
);

// File: tb/sim_serial_adc_ctrl.sv
`timescale 1ns/1ps
module sim_serial_adc_ctrl;
  localparam int CONV = 80;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rc_i = 1'b1, pd_i = 1'b0, ext_sel_i = 1'b0, ext_dclk_i = 1'b0;
  logic wr_a_ni = 1'b0, wr_b_ni = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [15:0] sample_i = 16'h0;
  logic busy_no, err_o, sdata_o, dclk_o, sync_o;
  logic [1:0] chan_o;

  always #2.5 clk = ~clk;

  serial_adc_ctrl #(.CONV_CYCLES(CONV)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rc_i(rc_i), .pd_i(pd_i),
    .ext_sel_i(ext_sel_i), .ext_dclk_i(ext_dclk_i), .wr_a_ni(wr_a_ni),
    .wr_b_ni(wr_b_ni), .addr_i(addr_i), .sample_i(sample_i), .busy_no(busy_no),
    .err_o(err_o), .sdata_o(sdata_o), .dclk_o(dclk_o), .sync_o(sync_o), .chan_o(chan_o)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // output monitor, sampled on the falling system edge
  logic clr = 1'b0;
  int rise_cnt = 0, mism = 0, run = 0, last_run = 0, low_total = 0, err_cnt = 0;
  logic [15:0] rx = '0;
  logic dclk_p = 1'b0, cur_bit = 1'b0;

  always @(negedge clk) begin
    if (clr) begin
      rise_cnt = 0; mism = 0; last_run = 0; low_total = 0; err_cnt = 0; rx = '0;
    end else begin
      if (dclk_o && !dclk_p) begin
        rise_cnt++;
        rx = {rx[14:0], sdata_o};
        cur_bit = sdata_o;
      end
      if (!dclk_o && dclk_p && sdata_o != cur_bit) mism++;
      if (!busy_no) begin run++; low_total++; end
      else if (run != 0) begin last_run = run; run = 0; end
      if (err_o) err_cnt++;
    end
    dclk_p = dclk_o;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int i);
    if (i == 0) return 16'hFFFF;
    if (i == 1) return 16'h0000;
    return 16'h8001 ^ 16'(i * 16'h3C5B);
  endfunction

  // R1 ordering: chip select low first, then strobe falls
  task automatic conv_rc(input logic [15:0] w);
    sample_i = w;
    cs_ni = 1'b0; wt(4); rc_i = 1'b0; wt(4); cs_ni = 1'b1; wt(4); rc_i = 1'b1; wt(4);
  endtask

  // R2 ordering: strobe low first, then chip select falls
  task automatic conv_cs(input logic [15:0] w);
    sample_i = w;
    rc_i = 1'b0; wt(4); cs_ni = 1'b0; wt(4); cs_ni = 1'b1; wt(4); rc_i = 1'b1; wt(4);
  endtask

  // read must already be opened; clocks out 16 bits plus a closing edge
  task automatic ext_shift(input logic [15:0] exp, input string tag);
    logic [15:0] w = '0;
    int sync_bad = 0;
    wt(6);
    for (int n = 0; n < 17; n++) begin
      ext_dclk_i = 1'b1; wt(6); ext_dclk_i = 1'b0; wt(6);
      if (n < 16) begin
        w = {w[14:0], sdata_o};
        if (sync_o != (n == 0)) sync_bad++;
      end
    end
    chk(w == exp, {tag, " R7 word"}, w, exp);
    chk(sync_bad == 0, "R7 sync position", sync_bad, 0);
  endtask

  task automatic ext_read_cs(input logic [15:0] exp, input string tag);
    cs_ni = 1'b0;
    ext_shift(exp, tag);
    cs_ni = 1'b1; wt(4);
  endtask

  logic [15:0] prev = 16'h0;

  initial begin
    wt(3); rst_ni = 1'b1; wt(2);
    // R10 reset state
    chk(busy_no == 1'b1, "R10 busy", busy_no, 1);
    chk({err_o, dclk_o, sync_o, sdata_o} == 4'b0, "R10 outputs", {err_o, dclk_o, sync_o, sdata_o}, 0);
    chk(chan_o == 2'd0, "R10 chan", chan_o, 0);

    // self-clocked sweep: each conversion carries the previous word
    for (int i = 0; i < 6; i++) begin
      clear();
      if (i % 2 == 0) conv_rc(pat(i)); else conv_cs(pat(i));
      wt(130);
      chk(last_run == CONV, (i % 2 == 0) ? "R1 R3 busy width" : "R2 R3 busy width", last_run, CONV);
      chk(rise_cnt == 16, "R6 pulse count", rise_cnt, 16);
      chk(rx == prev, "R6 word (R10 first is zero)", rx, prev);
      chk(mism == 0, "R6 edge stability", mism, 0);
      prev = pat(i);
    end

    // R4: second start while busy
    clear();
    sample_i = 16'h1234;
    cs_ni = 1'b0; wt(4); rc_i = 1'b0; wt(4); cs_ni = 1'b1; wt(4); rc_i = 1'b1; wt(20);
    conv_cs(16'hBEEF);
    wt(120);
    chk(err_cnt == 1, "R4 err pulse", err_cnt, 1);
    chk(last_run == CONV, "R4 busy width", last_run, CONV);
    prev = 16'h1234;
    clear(); conv_rc(16'h5A5A); wt(130);
    chk(rx == 16'h1234, "R4 result kept", rx, 16'h1234);
    prev = 16'h5A5A;

    // R5: power-down blocks starts
    pd_i = 1'b1; wt(5); clear();
    conv_rc(16'h0F0F); wt(120);
    chk(low_total == 0, "R5 busy held", low_total, 0);
    chk(rise_cnt == 0, "R5 no output", rise_cnt, 0);
    pd_i = 1'b0; wt(5); clear();
    conv_cs(16'h7777); wt(130);
    chk(rx == prev, "R5 result kept", rx, prev);
    prev = 16'h7777;

    // external-clock mode
    ext_sel_i = 1'b1; wt(5);
    ext_read_cs(prev, "R8 idle");
    for (int i = 2; i < 6; i++) begin
      logic [15:0] w = pat(i + 7);
      clear();
      conv_cs(w); wt(100);
      chk(rise_cnt == 0, "R6 ext dclk quiet", rise_cnt, 0);
      ext_read_cs(w, "R8 after");
      prev = w;
      // read during conversion: strobe rises with chip select low
      w = pat(i + 20);
      sample_i = w;
      rc_i = 1'b0; wt(4); cs_ni = 1'b0; wt(4); rc_i = 1'b1;
      ext_shift(prev, "R8 during");
      cs_ni = 1'b1; wt(10);
      ext_read_cs(w, "R8 after during");
      prev = w;
    end

    // R9: channel latch sweep
    for (int a = 0; a < 4; a++) begin
      for (int s = 0; s < 4; s++) begin
        wr_a_ni = 1'b0; wr_b_ni = 1'b0; addr_i = 2'(a); wt(2);
        chk(chan_o == 2'(a), "R9 open", chan_o, a);
        wr_a_ni = s[0]; wr_b_ni = s[1]; wt(1);
        addr_i = ~2'(a); wt(3);
        chk(chan_o == ((s == 0) ? ~2'(a) : 2'(a)), "R9 hold", chan_o,
            (s == 0) ? ~2'(a) : 2'(a));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule